// File: doc/BRIEF.md
# Byte-Level I2C Master Register Block

This block lets a processor run an I2C master one byte at a time through five byte registers: control, status, own address, data and line control. Register writes and reads are turned into byte-level bus jobs: a start that carries an address, a byte send, a byte receive and a stop. The block does not drive SCL or SDA itself. It hands each job to a bus engine through a request/done interface. The engine pulses done when the job finishes and reports whether it was acknowledged, together with any received byte.

Software paces the transfer through an interrupt-pending handshake. After each completed step the pending flag is set and the interrupt output goes high. To move on, software loads or reads the data register and then writes the pending flag to zero. If software clears the flag without touching the data register, the flag is raised again at once. While pending is clear, a data access can also launch the next step directly. Only one job is outstanding on the bus side at a time. The line control register only stores a value.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the data and own-address registers read 0xFF. Control, status and line control read 0x00, and irq is low.
- R2: Registers sit at offsets 0x00 control, 0x04 status, 0x08 own address, 0x0C data and 0x10 line control. Read data appears on the cycle after the read strobe. Any other offset reads 0, and writes to it change nothing.
- R3: Control bit 7 enables ack checking, bit 5 enables the interrupt and bit 4 is pending. A control write stores bits 7, 6, 5 and 3:0 but can never set pending.
- R4: Status bits 7:6 are the mode (2 = master receive, 3 = master transmit), bit 5 is busy, bit 4 is output enable and bit 0 is no-ack. A status write stores every bit except busy. When the written output-enable bit is 0, busy clears and irq drops.
- R5: In a master mode, a status write with bit 5 set does the following: clears bit 0, sets busy and requests a start (bus_op 0) with bus_byte equal to the data register (address in bits 7:1, direction in bit 0). In slave modes (mode bit 7 = 0), no request is made.
- R6: When a start, send or receive job completes with interrupt enable set, pending sets and irq rises. With interrupt enable clear, neither changes.
- R7: When a job completes with ack=0 and ack checking is on, status bit 0 sets and a receive leaves the data register unchanged. With ack checking off, bit 0 stays 0.
- R8: When an acknowledged start completes in master-receive mode, a receive (bus_op 2) is issued at once. The received byte is loaded into the data register and the interrupt is raised after that receive.
- R9: A data write is accepted only while output enable is 1. In master transmit with busy set and pending clear, the write requests a send (bus_op 1) of that byte.
- R10: A data read in master receive with busy set and pending clear requests a receive.
- R11: Writing 0 to a set pending flag clears pending and drops irq, and clears busy if interrupt enable is being written as 0. If still busy, the flag does one of two things. When the data register was accessed since the last job, the next send or receive for the mode starts. Otherwise, pending and irq are raised again at once.
- R12: In a master mode, a status write with bit 5 clear requests a stop (bus_op 3). Busy clears only if pending is clear.
- R13: The own-address register takes writes only while output enable is 0. The line control register stores any write.
- R14: At most one bus job is outstanding. An access that would start a second one still updates the registers but issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | One-cycle job request to the bus engine |
| bus_op | output | 2 | Job: 0 start, 1 send, 2 receive, 3 stop |
| bus_byte | output | 8 | Address byte for a start, data byte for a send |
| bus_done | input | 1 | Job finished pulse |
| bus_ack | input | 1 | Job was acknowledged, valid with bus_done |
| bus_rdata | input | 8 | Received byte, valid with bus_done |

## Verification
Transmit sequences run with random data bytes and random acknowledge replies. Comparing each requested byte and each no-ack bit with the bench's expectation separates the correct launch from a dropped or stale send. Directed receive sequences show whether a byte was loaded or kept on a no-ack, and whether the chained receive follows an acknowledged start. Clearing pending with and without a preceding data access tells a re-raise apart from a launch. A long-latency engine reply with a data write during the gap confirms that a second request is suppressed while storage still updates.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_OWN  = 'h08;
  localparam int OFF_DATA = 'h0C;
  localparam int OFF_LINE = 'h10;

  // control bits
  localparam int B_ACKCHK = 7;
  localparam int B_IEN    = 5;
  localparam int B_PEND   = 4;
  // status bits
  localparam int B_MODEHI = 7;
  localparam int B_BUSY   = 5;
  localparam int B_OE     = 4;
  localparam int B_NACK   = 0;

  localparam logic [1:0] MODE_MRX = 2'b10;
  localparam logic [1:0] MODE_MTX = 2'b11;
endpackage

// File: rtl/i2c_bm_txn.sv
module i2c_bm_txn
  import i2c_bm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  bus_op_e           launch_op,
  input  logic [BYTE_W-1:0] launch_byte,
  input  logic              bus_done,
  output logic              bus_req,
  output bus_op_e           cur_op,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              busy,
  output logic              done
);
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req  <= 1'b0;
      busy_q   <= 1'b0;
      cur_op   <= OP_START;
      cur_byte <= '0;
    end else begin
      bus_req <= launch;
      if (launch) begin
        busy_q   <= 1'b1;
        cur_op   <= launch_op;
        cur_byte <= launch_byte;
      end else if (bus_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = bus_done & busy_q;
endmodule

// File: rtl/i2c_bm_rdmux.sv
module i2c_bm_rdmux
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] own,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] line,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFF_OWN);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      case (addr)
        A_CTRL:  rdata <= ctrl;
        A_STAT:  rdata <= stat;
        A_OWN:   rdata <= own;
        A_DATA:  rdata <= data;
        A_LINE:  rdata <= line;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [DATA_W-1:0] bus_byte,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(OFF_OWN);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(OFF_LINE);
  localparam logic [DATA_W-1:0] ALL1   = {DATA_W{1'b1}};

  logic [DATA_W-1:0] ctrl_q, stat_q, own_q, data_q, line_q;
  logic              dacc_q, irq_q;
  logic [DATA_W-1:0] ctrl_n, stat_n, own_n, data_n, line_n;
  logic              dacc_n, irq_n;

  logic              launch;
  bus_op_e           launch_op;
  logic [DATA_W-1:0] launch_byte;
  logic              t_busy, t_done;
  bus_op_e           t_op;
  logic [DATA_W-1:0] t_byte;
  logic              slot_free;
  logic [1:0]        mode_n;
  logic              nack_hit;

  i2c_bm_txn #(.BYTE_W(DATA_W)) u_txn (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_op  (launch_op),
    .launch_byte(launch_byte),
    .bus_done   (bus_done),
    .bus_req    (bus_req),
    .cur_op     (t_op),
    .cur_byte   (t_byte),
    .busy       (t_busy),
    .done       (t_done)
  );

  i2c_bm_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk  (clk),
    .rst  (rst),
    .rd   (reg_rd),
    .addr (reg_addr),
    .ctrl (ctrl_q),
    .stat (stat_q),
    .own  (own_q),
    .data (data_q),
    .line (line_q),
    .rdata(reg_rdata)
  );

  assign slot_free = ~t_busy;
  assign nack_hit  = ~bus_ack & ctrl_q[B_ACKCHK];

  always_comb begin
    ctrl_n      = ctrl_q;
    stat_n      = stat_q;
    own_n       = own_q;
    data_n      = data_q;
    line_n      = line_q;
    dacc_n      = dacc_q;
    irq_n       = irq_q;
    launch      = 1'b0;
    launch_op   = OP_START;
    launch_byte = data_q;

    // completion of the outstanding job
    if (t_done) begin
      case (t_op)
        OP_START: begin
          if (nack_hit) begin
            stat_n[B_NACK] = 1'b1;
            if (ctrl_n[B_IEN]) begin ctrl_n[B_PEND] = 1'b1; irq_n = 1'b1; end
          end else if (stat_q[B_MODEHI -: 2] == MODE_MRX) begin
            stat_n[B_NACK] = 1'b0;
            dacc_n         = 1'b0;
            launch         = 1'b1;
            launch_op      = OP_RECV;
          end else if (ctrl_n[B_IEN]) begin
            ctrl_n[B_PEND] = 1'b1;
            irq_n          = 1'b1;
          end
        end
        OP_SEND, OP_RECV: begin
          if (nack_hit) stat_n[B_NACK] = 1'b1;
          else if (t_op == OP_RECV) data_n = bus_rdata;
          if (ctrl_n[B_IEN]) begin ctrl_n[B_PEND] = 1'b1; irq_n = 1'b1; end
        end
        default: ;
      endcase
    end

    mode_n = stat_n[B_MODEHI -: 2];

    // register writes
    if (reg_wr) begin
      case (reg_addr)
        A_CTRL: begin
          ctrl_n = (reg_wdata & ~(DATA_W'(1) << B_PEND)) | (ctrl_n & (DATA_W'(1) << B_PEND));
          if (ctrl_n[B_PEND] && !reg_wdata[B_PEND]) begin
            ctrl_n[B_PEND] = 1'b0;
            irq_n          = 1'b0;
            if (!reg_wdata[B_IEN]) stat_n[B_BUSY] = 1'b0;
            if (stat_n[B_BUSY]) begin
              if (dacc_n) begin
                if (slot_free && (mode_n == MODE_MTX || mode_n == MODE_MRX)) begin
                  stat_n[B_NACK] = 1'b0;
                  dacc_n         = 1'b0;
                  launch         = 1'b1;
                  launch_op      = (mode_n == MODE_MTX) ? OP_SEND : OP_RECV;
                  launch_byte    = data_n;
                end
              end else begin
                ctrl_n[B_PEND] = 1'b1;
                irq_n          = 1'b1;
              end
            end
          end
        end
        A_STAT: begin
          stat_n = (reg_wdata & ~(DATA_W'(1) << B_BUSY)) | (stat_n & (DATA_W'(1) << B_BUSY));
          if (!reg_wdata[B_OE]) begin
            stat_n[B_BUSY] = 1'b0;
            dacc_n         = 1'b1;
            irq_n          = 1'b0;
          end else if (reg_wdata[B_MODEHI]) begin
            if (reg_wdata[B_BUSY]) begin
              stat_n[B_NACK] = 1'b0;
              stat_n[B_BUSY] = 1'b1;
              dacc_n         = 1'b0;
              if (slot_free) begin
                launch      = 1'b1;
                launch_op   = OP_START;
                launch_byte = data_n;
              end
            end else begin
              if (slot_free) begin
                launch    = 1'b1;
                launch_op = OP_STOP;
              end
              if (!ctrl_n[B_PEND]) stat_n[B_BUSY] = 1'b0;
              dacc_n = 1'b1;
            end
          end
        end
        A_OWN: begin
          if (!stat_q[B_OE]) own_n = reg_wdata;
        end
        A_DATA: begin
          if (stat_q[B_OE]) begin
            data_n = reg_wdata;
            dacc_n = 1'b1;
            if (slot_free && mode_n == MODE_MTX && stat_n[B_BUSY] && !ctrl_n[B_PEND]) begin
              stat_n[B_NACK] = 1'b0;
              dacc_n         = 1'b0;
              launch         = 1'b1;
              launch_op      = OP_SEND;
              launch_byte    = reg_wdata;
            end
          end
        end
        A_LINE: line_n = reg_wdata;
        default: ;
      endcase
    end

    // data register read side effect
    if (reg_rd && reg_addr == A_DATA) begin
      dacc_n = 1'b1;
      if (slot_free && mode_n == MODE_MRX && stat_n[B_BUSY] && !ctrl_n[B_PEND]) begin
        stat_n[B_NACK] = 1'b0;
        dacc_n         = 1'b0;
        launch         = 1'b1;
        launch_op      = OP_RECV;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= '0;
      own_q  <= ALL1;
      data_q <= ALL1;
      line_q <= '0;
      dacc_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      stat_q <= stat_n;
      own_q  <= own_n;
      data_q <= data_n;
      line_q <= line_n;
      dacc_q <= dacc_n;
      irq_q  <= irq_n;
    end
  end

  assign irq      = irq_q;
  assign bus_op   = t_op;
  assign bus_byte = t_byte;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk
  import i2c_bm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic              bus_req,
  input logic              bus_done,
  input logic              pend,
  input logic              oe,
  input logic [DATA_W-1:0] own
);
  logic out_q;
  logic bad_off;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else if (bus_req) out_q <= 1'b1;
    else if (bus_done) out_q <= 1'b0;
  end

  assign bad_off = (reg_addr != ADDR_W'(OFF_CTRL)) && (reg_addr != ADDR_W'(OFF_STAT)) &&
                   (reg_addr != ADDR_W'(OFF_OWN))  && (reg_addr != ADDR_W'(OFF_DATA)) &&
                   (reg_addr != ADDR_W'(OFF_LINE));

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !out_q); // R14
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq |-> pend); // R6
  AST_OWN_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFF_OWN) && oe) |=> $stable(own)); // R13
  AST_BAD_OFFSET_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && bad_off) |=> (reg_rdata == '0)); // R2
  AST_PEND_NOT_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFF_CTRL) && !pend && !bus_done) |=> !pend); // R3
endmodule

bind i2c_byte_master i2c_byte_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_rdata(reg_rdata),
  .irq      (irq),
  .bus_req  (bus_req),
  .bus_done (bus_done),
  .pend     (ctrl_q[4]),
  .oe       (stat_q[4]),
  .own      (own_q)
);

// File: tb/i2c_byte_master_test.sv
`timescale 1ns/1ps
module i2c_byte_master_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, bus_req;
  logic [1:0] bus_op;
  logic [7:0] bus_byte;
  logic       bus_done = 1'b0, bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;

  int total = 0, bad = 0;
  int req_cnt = 0;
  logic [1:0] last_op = '0;
  logic [7:0] last_byte = '0;
  int rsp_lat = 3;
  logic rsp_ack = 1'b1;
  logic [7:0] rsp_rdata = '0;
  int countdown = 0;

  always #2 clk = ~clk;

  i2c_byte_master uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .bus_req(bus_req),
    .bus_op(bus_op), .bus_byte(bus_byte), .bus_done(bus_done), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata)
  );

  // bus engine model
  initial begin
    forever begin
      @(negedge clk);
      bus_done = 1'b0;
      if (countdown == 1) begin
        bus_done = 1'b1; bus_ack = rsp_ack; bus_rdata = rsp_rdata;
      end
      if (countdown > 0) countdown--;
      if (bus_req) begin
        req_cnt++; last_op = bus_op; last_byte = bus_byte; countdown = rsp_lat;
      end
    end
  end

  function automatic logic [7:0] stat_val(logic [1:0] mode, logic busy, logic oe, logic nack);
    return {mode, busy, oe, 3'b000, nack};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata; reg_rd = 1'b0;
  endtask

  task automatic idle();
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1 irq", irq, 0);
    rd(5'h00, v); check("R1 ctrl", v, 8'h00);
    rd(5'h04, v); check("R1 stat", v, 8'h00);
    rd(5'h08, v); check("R1 own", v, 8'hFF);
    rd(5'h0C, v); check("R1 data", v, 8'hFF);
    rd(5'h10, v); check("R1 line", v, 8'h00);

    // R2 bad offsets
    wr(5'h14, 8'h55);
    rd(5'h14, v); check("R2 bad read", v, 8'h00);
    rd(5'h02, v); check("R2 unaligned", v, 8'h00);
    rd(5'h10, v); check("R2 line untouched", v, 8'h00);

    // R13 own address and line control
    wr(5'h08, 8'h3C); rd(5'h08, v); check("R13 own write", v, 8'h3C);
    wr(5'h10, 8'hA5); rd(5'h10, v); check("R13 line", v, 8'hA5);
    // R9 data write with output disabled
    wr(5'h0C, 8'h12); rd(5'h0C, v); check("R9 data blocked", v, 8'hFF);

    // R3 pending not settable
    wr(5'h00, 8'hB0); rd(5'h00, v); check("R3 ctrl", v, 8'hA0);

    // R5/R6 transmit start
    wr(5'h04, 8'h10);
    wr(5'h08, 8'h11); rd(5'h08, v); check("R13 own locked", v, 8'h3C);
    wr(5'h0C, 8'hA4);
    base = req_cnt;
    rsp_ack = 1'b1;
    wr(5'h04, 8'hF0); idle();
    check("R5 one start", req_cnt - base, 1);
    check("R5 start op", last_op, 0);
    check("R5 start byte", last_byte, 8'hA4);
    rd(5'h04, v); check("R5 stat", v, stat_val(2'b11, 1, 1, 0));
    rd(5'h00, v); check("R6 pend", v, 8'hB0);
    check("R6 irq", irq, 1);

    // R9/R11 send after data access
    base = req_cnt;
    wr(5'h0C, 8'h5A);
    check("R9 no send while pending", req_cnt - base, 0);
    rsp_ack = 1'b0;
    wr(5'h00, 8'hA0); idle();
    check("R11 send launched", last_op, 1);
    check("R11 send byte", last_byte, 8'h5A);
    rd(5'h04, v); check("R7 nack set", v, stat_val(2'b11, 1, 1, 1));

    // R11 re-raise without data access
    base = req_cnt;
    wr(5'h00, 8'hA0);
    rd(5'h00, v); check("R11 reraise", v, 8'hB0);
    check("R11 irq back", irq, 1);
    check("R11 no request", req_cnt - base, 0);

    // random transmit bytes and replies
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      logic a;
      d = 8'($urandom); a = 1'($urandom);
      rsp_ack = a;
      wr(5'h0C, d);
      wr(5'h00, 8'hA0); idle();
      check("R9 random send op", last_op, 1);
      check("R9 random send byte", last_byte, d);
      rd(5'h04, v); check("R7 random nack", v, stat_val(2'b11, 1, 1, ~a));
    end

    // R4 output disable
    wr(5'h04, 8'h00);
    check("R4 irq drop", irq, 0);
    rd(5'h04, v); check("R4 busy clear", v, 8'h00);
    rd(5'h00, v); check("R4 pend kept", v, 8'hB0);
    wr(5'h00, 8'hA0);
    rd(5'h00, v); check("R11 idle clear", v, 8'hA0);

    // R12 stop with pending set
    rsp_ack = 1'b1;
    wr(5'h04, 8'h10); wr(5'h0C, 8'hA4); wr(5'h04, 8'hF0); idle();
    wr(5'h04, 8'hD0); idle();
    check("R12 stop op", last_op, 3);
    rd(5'h04, v); check("R12 busy held", v, stat_val(2'b11, 1, 1, 0));
    wr(5'h00, 8'h80);
    rd(5'h04, v); check("R11 ien off clears busy", v, stat_val(2'b11, 0, 1, 0));
    check("R11 irq low", irq, 0);

    // R7 ack checking off
    wr(5'h00, 8'h20);
    rsp_ack = 1'b0;
    wr(5'h04, 8'h10); wr(5'h0C, 8'hA4); wr(5'h04, 8'hF0); idle();
    rd(5'h04, v); check("R7 no check", v, stat_val(2'b11, 1, 1, 0));
    rd(5'h00, v); check("R6 pend ack off", v, 8'h30);
    wr(5'h00, 8'h00);

    // R8 receive chained after start
    wr(5'h00, 8'hA0);
    wr(5'h04, 8'h10); wr(5'h0C, 8'hA5);
    rsp_ack = 1'b1; rsp_rdata = 8'h6E;
    base = req_cnt;
    wr(5'h04, 8'hB0); idle();
    check("R8 two requests", req_cnt - base, 2);
    check("R8 recv op", last_op, 2);
    rd(5'h0C, v); check("R8 byte loaded", v, 8'h6E);
    check("R8 irq", irq, 1);
    rsp_rdata = 8'h19;
    wr(5'h00, 8'hA0); idle();
    rd(5'h0C, v); check("R11 next recv", v, 8'h19);
    rsp_ack = 1'b0; rsp_rdata = 8'h77;
    wr(5'h00, 8'hA0); idle();
    rd(5'h0C, v); check("R7 recv keeps data", v, 8'h19);
    rd(5'h04, v); check("R7 recv nack", v, stat_val(2'b10, 1, 1, 1));

    // R10 read-launched receive with interrupts off
    wr(5'h00, 8'h80);
    rsp_ack = 1'b1; rsp_rdata = 8'h42;
    wr(5'h04, 8'hB0); idle();
    check("R6 no irq when disabled", irq, 0);
    rsp_rdata = 8'h99;
    base = req_cnt;
    rd(5'h0C, v); check("R10 first byte", v, 8'h42);
    idle();
    check("R10 recv launched", req_cnt - base, 1);
    rd(5'h0C, v); check("R10 new byte", v, 8'h99);
    idle();

    // R12 stop with pending clear
    wr(5'h04, 8'h90); idle();
    check("R12 stop op2", last_op, 3);
    rd(5'h04, v); check("R12 busy cleared", v, stat_val(2'b10, 0, 1, 0));

    // R5 slave mode start ignored
    base = req_cnt;
    wr(5'h04, 8'h30); idle();
    check("R5 slave no request", req_cnt - base, 0);
    rd(5'h04, v); check("R5 slave busy", v, 8'h10);

    // R14 second job suppressed
    wr(5'h00, 8'h00);
    wr(5'h04, 8'h10); wr(5'h0C, 8'h40);
    rsp_lat = 8;
    base = req_cnt;
    wr(5'h04, 8'hF0);
    wr(5'h0C, 8'h77);
    idle();
    check("R14 single request", req_cnt - base, 1);
    check("R14 op", last_op, 0);
    rd(5'h0C, v); check("R14 storage", v, 8'h77);
    rsp_lat = 3;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule